// File: doc/BRIEF.md
# Edge-Triggered Interrupt Controller

This block gathers interrupt requests for a small soft processor into a single request line. It has a parameterized set of internal peripheral request lines and exactly two external interrupt pins. Every source is captured on an edge, not held as a level. A captured edge sets a pending flag. Each pending flag is gated by its own enable bit, and the combined result is gated by one global enable. The two external pins first pass through a two-flop synchronizer. Each external line has its own edge-polarity setting.

Software reaches the block through a simple single-cycle register bus. Writes take effect at the clock edge and reads are combinational.

- Offset 0 reads the pending flags. Writing 1 to a bit there clears that flag.
- Offset 1 is the enable (unmask) register.
- Offset 2 holds the polarity setting of the two external lines.
- Offset 3, bit 0, is the global enable.

The two kinds of source are cleared differently. A pending flag of an external line clears when the CPU pulses an acknowledge carrying that line's index. A pending flag of an internal source stays set until software clears it.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, pending reads 0, the enable register reads 0, polarity reads 2'b11, the global enable reads 0, and `irq_out` is low.
- R2: A rising edge on `int_req[i]` sets pending bit i at the clock edge where it is first sampled high. A level held high does not set the bit again once it has been cleared.
- R3: `irq_out` is high exactly when the global enable is 1 and some pending bit has its enable bit set.
- R4: The enable register at offset 1 is read/write over bits [N-1:0], where N = NUM_INT+2. A pending bit whose enable bit is 0 still reads back at offset 0 but does not raise `irq_out`.
- R5: `irq_out` stays low while offset 3 bit 0 is 0, whatever the pending and enable bits hold.
- R6: External line j maps to pending bit NUM_INT+j. Polarity bit j (offset 2) selects the edge that sets it: 1 selects a rising edge, 0 selects a falling edge. The opposite edge has no effect.
- R7: External pins pass through two synchronizer flops. For a pin change first sampled at clock edge k, the pending bit is still 0 after edge k+1 and is 1 after edge k+2.
- R8: A one-cycle `ack_valid` pulse with `ack_idx` = NUM_INT+j clears pending bit NUM_INT+j. An acknowledge naming an internal index changes no pending bit.
- R9: Internal pending bits clear only through a write to offset 0 with a 1 in that bit position. Writing 0s to offset 0 leaves pending unchanged.
- R10: If a new edge on a source arrives in the same cycle as a clear of that source, the pending bit stays set.
- R11: Changing a polarity bit while the external pin is stable does not set the pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | NUM_INT | Internal peripheral request lines, synchronous to clk |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| ack_valid | input | 1 | One-cycle acknowledge pulse from the CPU |
| ack_idx | input | IDX_W | Index of the source being acknowledged |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The bench first checks that a level held high does not re-trigger after software clears it. A level-sensitive design would re-set the flag at once. It then times the external path edge by edge. A design that skipped or doubled a synchronizer stage would show the flag one cycle early or late.

Next, an edge and a write-1-to-clear are made to land in the same cycle. A design that gave the clear priority would lose the event. The bench also acknowledges an internal index and changes polarity under a steady pin. Here a faulty design would wrongly clear an internal flag or invent a spurious external event.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // register offsets
   localparam int OFF_PEND = 0;
   localparam int OFF_MASK = 1;
   localparam int OFF_POL  = 2;
   localparam int OFF_CTRL = 3;
   // external line count is fixed
   localparam int EXT_LINES = 2;
   // polarity reset: both lines sense rising edges
   localparam logic [EXT_LINES-1:0] POL_RESET = '1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("irq_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   input  logic [WIDTH-1:0] rise_sel,   // 1 = rising, 0 = falling
   output logic [WIDTH-1:0] evt
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign evt = (lvl & ~prev_q & rise_sel) | (~lvl & prev_q & ~rise_sel);
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_v,
   input  logic [WIDTH-1:0] clr_v,
   output logic [WIDTH-1:0] pend
);
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pend[b] <= 1'b0;
            else if (set_v[b]) pend[b] <= 1'b1;   // a new edge beats a clear
            else if (clr_v[b]) pend[b] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
   parameter int N      = 8,
   parameter int EXT_N  = 2,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N-1:0]      pend,
   output logic [DATA_W-1:0] rdata,
   output logic [N-1:0]      mask,
   output logic [EXT_N-1:0]  pol,
   output logic              gen_en,
   output logic [N-1:0]      wr_clr
);
   import irq_pkg::*;

   logic wr;
   assign wr = sel & we;

   logic hit_pend, hit_mask, hit_pol, hit_ctrl;
   assign hit_pend = (addr == ADDR_W'(OFF_PEND));
   assign hit_mask = (addr == ADDR_W'(OFF_MASK));
   assign hit_pol  = (addr == ADDR_W'(OFF_POL));
   assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));

   assign wr_clr = (wr && hit_pend) ? wdata[N-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask   <= '0;
         pol    <= POL_RESET[EXT_N-1:0];
         gen_en <= 1'b0;
      end else if (wr) begin
         if (hit_mask) mask   <= wdata[N-1:0];
         if (hit_pol)  pol    <= wdata[EXT_N-1:0];
         if (hit_ctrl) gen_en <= wdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_pend)      rdata[N-1:0]     = pend;
      else if (hit_mask) rdata[N-1:0]     = mask;
      else if (hit_pol)  rdata[EXT_N-1:0] = pol;
      else if (hit_ctrl) rdata[0]         = gen_en;
   end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
   parameter int NUM_INT     = 6,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   localparam int EXT_N      = irq_pkg::EXT_LINES,
   localparam int N          = NUM_INT + EXT_N,
   localparam int IDX_W      = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_INT-1:0] int_req,
   input  logic [EXT_N-1:0]  ext_pin,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ack_valid,
   input  logic [IDX_W-1:0]  ack_idx,
   output logic              irq_out
);
   generate
      if (NUM_INT < 1)  begin : g_chk_int  $error("NUM_INT must be at least 1"); end
      if (N > DATA_W)   begin : g_chk_w    $error("sources exceed DATA_W"); end
      if (ADDR_W < 2)   begin : g_chk_a    $error("ADDR_W must cover four offsets"); end
   endgenerate

   logic [EXT_N-1:0]   ext_sync;
   logic [EXT_N-1:0]   pol;
   logic [NUM_INT-1:0] int_evt;
   logic [EXT_N-1:0]   ext_evt;
   logic [N-1:0]       edge_vec;
   logic [N-1:0]       pend_q;
   logic [N-1:0]       mask_q;
   logic [N-1:0]       wr_clear;
   logic [N-1:0]       ack_clr;
   logic               gen_en;

   irq_sync #(.WIDTH(EXT_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_sync));

   irq_edge_det #(.WIDTH(NUM_INT)) u_int_edge (
      .clk(clk), .rst_n(rst_n), .lvl(int_req), .rise_sel({NUM_INT{1'b1}}), .evt(int_evt));

   irq_edge_det #(.WIDTH(EXT_N)) u_ext_edge (
      .clk(clk), .rst_n(rst_n), .lvl(ext_sync), .rise_sel(pol), .evt(ext_evt));

   assign edge_vec = {ext_evt, int_evt};

   // acknowledge clears only external lines
   generate
      for (genvar i = 0; i < N; i++) begin : g_ack
         if (i >= NUM_INT) begin : g_ext
            assign ack_clr[i] = ack_valid && (ack_idx == IDX_W'(i));
         end else begin : g_int
            assign ack_clr[i] = 1'b0;
         end
      end
   endgenerate

   irq_pend #(.WIDTH(N)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_v(edge_vec), .clr_v(wr_clear | ack_clr), .pend(pend_q));

   irq_regs #(.N(N), .EXT_N(EXT_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .pend(pend_q), .rdata(bus_rdata), .mask(mask_q),
      .pol(pol), .gen_en(gen_en), .wr_clr(wr_clear));

   assign irq_out = gen_en & (|(pend_q & mask_q));
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
   parameter int NUM_INT = 6,
   parameter int N       = 8,
   parameter int IDX_W   = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_out,
   input logic             gen_en,
   input logic [N-1:0]     pend_q,
   input logic [N-1:0]     mask_q,
   input logic [N-1:0]     edge_vec,
   input logic [N-1:0]     wr_clear,
   input logic             ack_valid,
   input logic [IDX_W-1:0] ack_idx
);
   // R1
   reset_state_chk: assert property (@(posedge clk) !rst_n |-> (pend_q == '0 && mask_q == '0 && !gen_en));

   // R5
   global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_out |-> gen_en);

   // R3
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_out |-> ((pend_q & mask_q) != '0));

   // R10
   edge_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_vec != '0) |=> ((pend_q & $past(edge_vec)) == $past(edge_vec)));

   // R9
   int_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~pend_q[NUM_INT-1:0] & $past(pend_q[NUM_INT-1:0])) != '0) |-> ($past(wr_clear) != '0));

   // R8
   ack_ext0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_idx == IDX_W'(NUM_INT) && !edge_vec[NUM_INT]) |=> !pend_q[NUM_INT]);

   // R8
   ack_ext1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_idx == IDX_W'(NUM_INT+1) && !edge_vec[NUM_INT+1]) |=> !pend_q[NUM_INT+1]);
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.NUM_INT(NUM_INT), .N(N), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .gen_en(gen_en), .pend_q(pend_q),
   .mask_q(mask_q), .edge_vec(edge_vec), .wr_clear(wr_clear),
   .ack_valid(ack_valid), .ack_idx(ack_idx));

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;
   localparam int NI = 6;
   localparam int N  = NI + 2;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] int_req = '0;
   logic [1:0]    ext_pin = '0;
   logic          bus_sel = 1'b0, bus_we = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          ack_valid = 1'b0;
   logic [2:0]    ack_idx = '0;
   logic          irq_out;

   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   edge_irq_ctrl #(.NUM_INT(NI)) u0 (
      .clk(clk), .rst_n(rst_n), .int_req(int_req), .ext_pin(ext_pin),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_idx(ack_idx), .irq_out(irq_out));

   task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic ack(input logic [2:0] idx);
      @(negedge clk);
      ack_valid = 1; ack_idx = idx;
      @(negedge clk);
      ack_valid = 0;
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      @(negedge clk);
      rd(2'd0, d); chk("R1 pending", d, 0);
      rd(2'd1, d); chk("R1 mask", d, 0);
      rd(2'd2, d); chk("R1 polarity", d, 32'h3);
      rd(2'd3, d); chk("R1 global", d, 0);
      chk("R1 irq_out", {31'd0, irq_out}, 0);
   endtask

   task automatic t_internal();
      logic [DW-1:0] d;
      @(negedge clk); int_req[2] = 1;
      @(negedge clk);
      rd(2'd0, d); chk("R2 rising edge sets bit", d, 32'h4);
      chk("R4 masked no irq", {31'd0, irq_out}, 0);
      wr(2'd0, 32'h0);
      rd(2'd0, d); chk("R9 write zero keeps", d, 32'h4);
      wr(2'd0, 32'h4);
      cyc(3);
      rd(2'd0, d); chk("R2 held level no retrigger", d, 0);
      int_req[2] = 0;
      cyc(1);
   endtask

   task automatic t_mask_global();
      logic [DW-1:0] d;
      @(negedge clk); int_req[2] = 1;
      @(negedge clk); int_req[2] = 0;
      wr(2'd1, 32'h4);
      rd(2'd1, d); chk("R4 mask readback", d, 32'h4);
      chk("R5 global off", {31'd0, irq_out}, 0);
      wr(2'd3, 32'h1);
      chk("R3 irq raised", {31'd0, irq_out}, 1);
      wr(2'd1, 32'h0);
      chk("R4 unmasked off", {31'd0, irq_out}, 0);
      rd(2'd0, d); chk("R4 pending still set", d, 32'h4);
      wr(2'd0, 32'h4);
      wr(2'd1, 32'hFF);
      chk("R3 no pending no irq", {31'd0, irq_out}, 0);
   endtask

   task automatic t_ext_rising();
      logic [DW-1:0] d;
      ext_pin[0] = 1;          // first sampled at next edge k
      @(negedge clk);          // after k
      @(negedge clk);          // after k+1
      rd(2'd0, d); chk("R7 not yet after k+1", d, 0);
      @(negedge clk);          // after k+2
      rd(2'd0, d); chk("R7 R6 set after k+2", d, 32'h1 << NI);
      chk("R3 ext irq", {31'd0, irq_out}, 1);
      @(negedge clk); int_req[1] = 1;
      @(negedge clk); int_req[1] = 0;
      ack(3'd1);
      rd(2'd0, d); chk("R8 internal ack ignored", d, (32'h1 << NI) | 32'h2);
      ack(3'(NI));
      rd(2'd0, d); chk("R8 ext ack clears", d, 32'h2);
      wr(2'd0, 32'h2);
      ext_pin[0] = 0;
      cyc(4);
      rd(2'd0, d); chk("R6 falling ignored on rising line", d, 0);
   endtask

   task automatic t_ext_falling();
      logic [DW-1:0] d;
      wr(2'd2, 32'h1);         // line1 falling
      ext_pin[1] = 1;
      cyc(4);
      rd(2'd0, d); chk("R6 rising ignored on falling line", d, 0);
      ext_pin[1] = 0;
      cyc(4);
      rd(2'd0, d); chk("R6 falling sets line1", d, 32'h1 << (NI+1));
      ack(3'(NI+1));
      rd(2'd0, d); chk("R8 line1 ack", d, 0);
      wr(2'd2, 32'h3);         // pin low and stable
      cyc(4);
      rd(2'd0, d); chk("R11 polarity change no event", d, 0);
      ext_pin[1] = 1;
      cyc(4);
      ack(3'(NI+1));
   endtask

   task automatic t_collide();
      logic [DW-1:0] d;
      @(negedge clk); int_req[3] = 1;
      @(negedge clk); int_req[3] = 0;
      rd(2'd0, d); chk("R2 bit3 set", d, 32'h8);
      @(negedge clk);
      int_req[3] = 1;
      bus_sel = 1; bus_we = 1; bus_addr = 2'd0; bus_wdata = 32'h8;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
      rd(2'd0, d); chk("R10 edge beats clear", d, 32'h8);
      int_req[3] = 0;
      wr(2'd0, 32'h8);
      rd(2'd0, d); chk("R9 cleared", d, 0);
   endtask

   initial begin
      cyc(3);
      rst_n = 1;
      t_reset();
      t_internal();
      t_mask_global();
      t_ext_rising();
      t_ext_falling();
      t_collide();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule